// File: doc/BRIEF.md
# Super-I/O Configuration Port Controller

This block implements the configuration window of a legacy Super-I/O device. It has two byte-wide ports on a simple strobe bus: an index port (address bit 0) and a data port (address bit 1). Software writes a register number to the index port and then reads or writes that register through the data port. The window stays shut until the unlock key is written twice in a row to the index port. A lock key closes it again.

Behind the window are global registers for device identity, vendor identity, revision and the logical-device selector. Above index 0x30 the register space is banked. The selector picks which logical device answers there. Each logical device keeps its enable bit inside this block. Every other register of that device lives in the attached function block, which this block reaches through per-device read and write strobes, a shared index, shared write data, and a per-device read byte.

The bus is a plain strobe interface with no back-pressure. Every access completes in the cycle its strobe is high. Read data is registered and appears on the cycle after the read strobe. The function-block strobes carry no ready signal: the function block must accept a write, and present its read byte, in the same cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked, the device selector is 0, every device enable is 0, the latched index is 0x00 and `io_rdata` is 0xFF.
- R2: The window opens only after two index-port writes of 0x87 in a row. Any other index-port write between them restarts the count. Data-port accesses do not affect the count.
- R3: While open, an index-port write of 0xAA locks the window and leaves the latched index unchanged. Any other index-port write stores its value as the new index.
- R4: While locked, data-port writes change nothing and raise no strobe. Reads of either port return 0xFF.
- R5: A read returns its byte on `io_rdata` in the cycle after `io_rd`. That value holds until the next read.
- R6: Index 0x20/0x21 read the device ID high/low byte, 0x22 reads the revision, and 0x23/0x24 read the vendor ID 0x1934 high/low byte. Writes to these indices have no effect.
- R7: Index 0x07 is the device selector. A write keeps the low log2(NUM_LD) bits, and a read returns them with the upper bits zero.
- R8: Index 0x30 reads and writes bit 0 as the enable of the selected device, and the other bits read 0. `ld_en[i]` shows the enable of device i.
- R9: A data-port access to an index above 0x30 pulses `ld_wr` or `ld_rd` in the same cycle, for the selected device only. `ld_idx` and `ld_wdata` carry the index and the data. A read returns that device's byte of `ld_rdata`.
- R10: Indices below 0x30 that are not listed in R6 or R7 read 0x00 and ignore writes.
- R11: While open, a read of the index port returns the latched index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| ld_en | output | NUM_LD | Per-device enable bits |
| ld_wr | output | NUM_LD | Per-device register write strobe |
| ld_rd | output | NUM_LD | Per-device register read strobe |
| ld_idx | output | 8 | Register index presented to the function block |
| ld_wdata | output | 8 | Write data presented to the function block |
| ld_rdata | input | NUM_LD*8 | Read bytes from the function blocks, device i at bits 8i+7:8i |

## Verification
The assertions assume that `io_rd` and `io_wr` are never high in the same cycle and that the bus inputs change only away from the clock edge. The held-read-data and stable-enable properties depend on this, because they treat any cycle without a strobe as idle. The bench issues one access at a time, each strobe lasting a single cycle, and drives inputs one nanosecond after the rising edge. The function-block read bytes are fixed per device, so any mix-up of bank routing shows up directly on `io_rdata`.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_UNLOCK   = 8'h87;
  localparam logic [7:0] KEY_LOCK     = 8'hAA;
  localparam logic [7:0] IDX_LDSEL    = 8'h07;
  localparam logic [7:0] IDX_DEVID_HI = 8'h20;
  localparam logic [7:0] IDX_DEVID_LO = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_VEND_HI  = 8'h23;
  localparam logic [7:0] IDX_VEND_LO  = 8'h24;
  localparam logic [7:0] IDX_BANK     = 8'h30;
  localparam logic [7:0] RD_LOCKED    = 8'hFF;

  typedef enum logic [1:0] {
    KS_SHUT = 2'd0,
    KS_HALF = 2'd1,
    KS_OPEN = 2'd2
  } key_state_t;
endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic [7:0] idx
);
  key_state_t st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= KS_SHUT;
      idx  <= 8'h00;
    end else if (idx_wr) begin
      case (st_q)
        KS_SHUT: st_q <= (wdata == KEY_UNLOCK) ? KS_HALF : KS_SHUT;
        KS_HALF: st_q <= (wdata == KEY_UNLOCK) ? KS_OPEN : KS_SHUT;
        KS_OPEN: begin
          if (wdata == KEY_LOCK) st_q <= KS_SHUT;
          else                   idx  <= wdata;
        end
        default: st_q <= KS_SHUT;
      endcase
    end
  end

  assign open = (st_q == KS_OPEN);
endmodule

// File: rtl/sio_glob_regs.sv
module sio_glob_regs
  import sio_cfg_pkg::*;
#(
  parameter int          LD_W      = 3,
  parameter logic [15:0] DEV_ID    = 16'h0A5C,
  parameter logic [7:0]  REV       = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            data_wr,
  input  logic [7:0]      idx,
  input  logic [LD_W-1:0] wsel,
  output logic [LD_W-1:0] ldn,
  output logic [7:0]      rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ldn <= '0;
    else if (data_wr && idx == IDX_LDSEL) ldn <= wsel;
  end

  always_comb begin
    case (idx)
      IDX_LDSEL:    rdata = 8'(ldn);
      IDX_DEVID_HI: rdata = DEV_ID[15:8];
      IDX_DEVID_LO: rdata = DEV_ID[7:0];
      IDX_REV:      rdata = REV;
      IDX_VEND_HI:  rdata = VENDOR_ID[15:8];
      IDX_VEND_LO:  rdata = VENDOR_ID[7:0];
      default:      rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/sio_ld_bank.sv
module sio_ld_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LD = 8,
  parameter int LD_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [7:0]        idx,
  input  logic [LD_W-1:0]   ldn,
  input  logic              en_bit,
  input  logic [NUM_LD*8-1:0] fn_rdata,
  output logic [NUM_LD-1:0] en,
  output logic [NUM_LD-1:0] fn_wr,
  output logic [NUM_LD-1:0] fn_rd,
  output logic [7:0]        rdata
);
  logic above;
  assign above = (idx > IDX_BANK);

  for (genvar g = 0; g < NUM_LD; g++) begin : g_dev
    logic sel;
    assign sel = (ldn == LD_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               en[g] <= 1'b0;
      else if (data_wr && sel && idx == IDX_BANK) en[g] <= en_bit;
    end
    assign fn_wr[g] = data_wr && sel && above;
    assign fn_rd[g] = data_rd && sel && above;
  end

  always_comb begin
    rdata = 8'h00;
    for (int i = 0; i < NUM_LD; i++) begin
      if (ldn == LD_W'(i)) begin
        rdata = above ? fn_rdata[i*8 +: 8] : {7'b0, en[i]};
      end
    end
  end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LD    = 8,
  parameter logic [15:0] DEV_ID    = 16'h0A5C,
  parameter logic [7:0]  REV       = 8'h01,
  parameter logic [15:0] VENDOR_ID = 16'h1934
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                io_addr,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [7:0]          io_wdata,
  output logic [7:0]          io_rdata,
  output logic [NUM_LD-1:0]   ld_en,
  output logic [NUM_LD-1:0]   ld_wr,
  output logic [NUM_LD-1:0]   ld_rd,
  output logic [7:0]          ld_idx,
  output logic [7:0]          ld_wdata,
  input  logic [NUM_LD*8-1:0] ld_rdata
);
  localparam int LD_W = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;

  logic            cfg_open;
  logic [7:0]      cur_idx;
  logic [LD_W-1:0] ldn;
  logic [7:0]      glob_rdata;
  logic [7:0]      bank_rdata;
  logic            data_wr;
  logic            data_rd;

  assign data_wr = io_wr && io_addr && cfg_open;
  assign data_rd = io_rd && io_addr && cfg_open;

  sio_key_seq u_key (
    .clk    (clk),
    .rst_n  (rst_n),
    .idx_wr (io_wr && !io_addr),
    .wdata  (io_wdata),
    .open   (cfg_open),
    .idx    (cur_idx)
  );

  sio_glob_regs #(
    .LD_W      (LD_W),
    .DEV_ID    (DEV_ID),
    .REV       (REV),
    .VENDOR_ID (VENDOR_ID)
  ) u_glob (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_wr (data_wr),
    .idx     (cur_idx),
    .wsel    (io_wdata[LD_W-1:0]),
    .ldn     (ldn),
    .rdata   (glob_rdata)
  );

  sio_ld_bank #(
    .NUM_LD (NUM_LD),
    .LD_W   (LD_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .idx      (cur_idx),
    .ldn      (ldn),
    .en_bit   (io_wdata[0]),
    .fn_rdata (ld_rdata),
    .en       (ld_en),
    .fn_wr    (ld_wr),
    .fn_rd    (ld_rd),
    .rdata    (bank_rdata)
  );

  assign ld_idx   = cur_idx;
  assign ld_wdata = io_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rdata <= RD_LOCKED;
    end else if (io_rd) begin
      if (!cfg_open)              io_rdata <= RD_LOCKED;
      else if (!io_addr)          io_rdata <= cur_idx;
      else if (cur_idx >= IDX_BANK) io_rdata <= bank_rdata;
      else                        io_rdata <= glob_rdata;
    end
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter int NUM_LD = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic [NUM_LD-1:0] ld_en,
  input logic [NUM_LD-1:0] ld_wr,
  input logic [NUM_LD-1:0] ld_rd,
  input logic              cfg_open
);
  // R2
  open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && !io_addr && io_wdata == 8'h87));

  // R3
  lock_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_addr && io_wdata == 8'hAA) |=> !cfg_open);

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> (ld_wr == '0 && ld_rd == '0));

  // R5
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  // R8
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_wr |=> $stable(ld_en));

  // R9
  one_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_wr) && $onehot0(ld_rd));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LD(NUM_LD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .io_addr  (io_addr),
  .io_wr    (io_wr),
  .io_rd    (io_rd),
  .io_wdata (io_wdata),
  .io_rdata (io_rdata),
  .ld_en    (ld_en),
  .ld_wr    (ld_wr),
  .ld_rd    (ld_rd),
  .cfg_open (cfg_open)
);

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         io_addr = 1'b0;
  logic         io_wr = 1'b0;
  logic         io_rd = 1'b0;
  logic [7:0]   io_wdata = 8'h00;
  logic [7:0]   io_rdata;
  logic [N-1:0] ld_en, ld_wr, ld_rd;
  logic [7:0]   ld_idx, ld_wdata;
  logic [N*8-1:0] ld_rdata;

  int checks = 0;
  int errors = 0;
  bit live = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  for (genvar g = 0; g < N; g++) begin : g_fn
    assign ld_rdata[g*8 +: 8] = 8'h50 + 8'(g);
  end

  sio_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ld_en(ld_en), .ld_wr(ld_wr),
    .ld_rd(ld_rd), .ld_idx(ld_idx), .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
  );

  // Behavioural reference: 0 shut, 1 one key seen, 2 open
  int       m_st;
  logic [7:0] m_idx, m_ldn, m_rdata;
  logic [N-1:0] m_en;

  function automatic logic [7:0] exp_read();
    if (m_st != 2) return 8'hFF;
    if (!io_addr) return m_idx;
    if (m_idx == 8'h30) return {7'b0, m_en[m_ldn]};
    if (m_idx > 8'h30) return 8'h50 + m_ldn;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'h0A;
      8'h21: return 8'h5C;
      8'h22: return 8'h01;
      8'h23: return 8'h19;
      8'h24: return 8'h34;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 8'h00; m_ldn = 8'h00; m_en = '0; m_rdata = 8'hFF;
    end else begin
      if (io_rd) m_rdata = exp_read();
      if (io_wr && !io_addr) begin
        if (m_st == 2) begin
          if (io_wdata == 8'hAA) m_st = 0;
          else m_idx = io_wdata;
        end else if (io_wdata == 8'h87) m_st = m_st + 1;
        else m_st = 0;
      end else if (io_wr && m_st == 2) begin
        if (m_idx == 8'h07) m_ldn = io_wdata & 8'h07;
        else if (m_idx == 8'h30) m_en[m_ldn] = io_wdata[0];
      end
    end
  end

  task automatic cmp8(string what, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live) begin
      logic [N-1:0] ew, er;
      ew = '0; er = '0;
      if (m_st == 2 && io_addr && m_idx > 8'h30) begin
        if (io_wr) ew[m_ldn] = 1'b1;
        if (io_rd) er[m_ldn] = 1'b1;
      end
      cmp8("io_rdata", io_rdata, m_rdata);
      cmp8("ld_en", ld_en, m_en);
      cmp8("ld_wr", ld_wr, ew);
      cmp8("ld_rd", ld_rd, er);
      if (ew != 0 || er != 0) cmp8("ld_idx", ld_idx, m_idx);
      if (ew != 0) cmp8("ld_wdata", ld_wdata, io_wdata);
    end
  end

  task automatic wr(bit a, logic [7:0] d);
    @(posedge clk); #1;
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(bit a);
    @(posedge clk); #1;
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic rreg(logic [7:0] i);
    wr(0, i); rd(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    live = 1'b1;
    // R1: reset state, locked reads
    cur_req = "R1";
    repeat (2) @(posedge clk);
    rd(1); rd(0);
    // R2: interrupted key, data access while half-open
    cur_req = "R2";
    wr(0, 8'h87); wr(0, 8'h11); wr(0, 8'h87);
    wr(1, 8'h01); rd(1);
    wr(0, 8'h87);
    // R11: index port readback (still 0 after reset), then new index
    cur_req = "R11";
    rd(0);
    wr(0, 8'h22); rd(0);
    // R6: identity and read-only
    cur_req = "R6";
    for (int i = 8'h20; i <= 8'h24; i++) rreg(8'(i));
    wr(0, 8'h20); wr(1, 8'h00); rd(1);
    // R10: undefined globals
    cur_req = "R10";
    rreg(8'h25); rreg(8'h00);
    wr(0, 8'h10); wr(1, 8'h77); rd(1);
    // R7: selector masking
    cur_req = "R7";
    wr(0, 8'h07); wr(1, 8'hFD); rd(1);
    // R8: enables per device
    cur_req = "R8";
    for (int d = 0; d < N; d++) begin
      wr(0, 8'h07); wr(1, 8'(d));
      wr(0, 8'h30); wr(1, (d % 2 == 0) ? 8'hFF : 8'h00); rd(1);
    end
    wr(0, 8'h07); wr(1, 8'h07); wr(0, 8'h30); wr(1, 8'hFE); rd(1);
    // R9: banked function-block access
    cur_req = "R9";
    wr(0, 8'h07); wr(1, 8'h03);
    wr(0, 8'h31); wr(1, 8'h5A); rd(1);
    wr(0, 8'hF0); wr(1, 8'hC3); rd(1);
    wr(0, 8'h07); wr(1, 8'h06); wr(0, 8'hF0); rd(1);
    // R5: read data holds across idle cycles
    cur_req = "R5";
    repeat (5) @(posedge clk);
    // R3: lock key, index kept
    cur_req = "R3";
    wr(0, 8'hAA);
    // R4: locked window ignores data writes
    cur_req = "R4";
    wr(1, 8'h00); rd(1); rd(0);
    wr(0, 8'h30); wr(1, 8'h00); rd(1);
    cur_req = "R3";
    wr(0, 8'h87); wr(0, 8'h87); rd(0);
    wr(0, 8'h30); rd(1);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R1..R11 run hung got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule